// File: doc/BRIEF.md
# Multi-Profile First-Order IIR Amplitude Servo

This block closes an amplitude loop for one output channel. Each time a new signed ADC sample arrives, it runs a first-order IIR recurrence and updates the loop output `y`. That output then multiplies a pair of 16-bit I/Q sample streams, which sets the channel amplitude. The block keeps four coefficient profiles, and a 2-bit index selects one. Every profile has its own feedforward gains, feedback gain and offset, and its own two-deep output history. All profiles share one two-deep history of input samples.

Two controls change the behaviour. The hold control freezes the output history while input samples continue to shift in. When the enable control is low, the block passes I/Q through unscaled and also freezes the filter, because the loop is open. The recurrence runs as a short multi-cycle multiply-accumulate sequence that finishes far inside the roughly 264 ns gap between ADC samples. A one-cycle done strobe marks each new output.

Top module: `iir_servo_channel`

## Requirements
- R1: While reset is asserted and after it is released, `y_out`, `y_prev`, `i_out`, `q_out` and `y_done` are all zero, and every stored input and output history word is zero.
- R2: On an update, the block forms `acc = offset*2^14 + b0*x0 + b1*x1 + a1*y0`. Here `x0` is the newest sample, `x1` is the sample before it, `y0` is the active profile's last output, and all words are 16-bit two's complement. The new output is `acc` arithmetically shifted right by 14 bits (rounding toward minus infinity).
- R3: The new output is clipped to the range 0x0000..0x7FFF. A negative shifted result gives 0x0000, and a result above 0x7FFF gives 0x7FFF.
- R4: `profile_sel` (0..3) picks the profile. `y_out` and `y_prev` show that profile's stored `y0` and `y1` combinationally, and each profile's history changes only on its own updates.
- R5: When a sample is accepted, `x1` takes the old `x0` and `x0` takes `adc_sample`. This happens regardless of profile, hold or enable.
- R6: With `servo_hold` high, an accepted sample still shifts the input history, but no output history changes and `y_done` stays low.
- R7: With `servo_en` low, `i_out`/`q_out` equal `i_in`/`q_in` one cycle later. Accepted samples behave as under hold.
- R8: With `servo_en` high, `i_out`/`q_out` equal `floor(in * y_out / 2^15)` of the previous cycle's inputs. This is a one-cycle registered path.
- R9: `y_done` pulses for exactly one cycle, 4 clock edges after the edge that accepts the sample. On that same edge `y0` takes the new output and `y1` takes the old `y0`, for the profile that was selected at acceptance.
- R10: A sample strobed while an update is in progress is ignored entirely, including by the input history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_valid | input | 1 | New ADC sample strobe |
| adc_sample | input | 16 | Signed ADC sample, MSB-aligned |
| profile_sel | input | 2 | Active profile index |
| servo_en | input | 1 | 1 scales I/Q and runs the filter |
| servo_hold | input | 1 | 1 freezes the output history |
| coef_b0 | input | 4x16 | Per-profile gain on newest sample |
| coef_b1 | input | 4x16 | Per-profile gain on previous sample |
| coef_a1 | input | 4x16 | Per-profile feedback gain |
| coef_off | input | 4x16 | Per-profile output offset |
| i_in | input | 16 | Signed I sample |
| q_in | input | 16 | Signed Q sample |
| i_out | output | 16 | Scaled or bypassed I sample |
| q_out | output | 16 | Scaled or bypassed Q sample |
| y_out | output | 16 | Selected profile's current output |
| y_prev | output | 16 | Selected profile's previous output |
| y_done | output | 1 | New output registered |

## Verification
A corrupted shared input history appears at the ports on the next update of any profile, through its `b1` term. The bench exposes this by switching profile right after a held or disabled sample. A wrong feedback or history word shows on `y_out`/`y_prev` as soon as the affected profile is selected, and at the latest when `y_done` fires for its next update. A scaler error appears on `i_out`/`q_out` one cycle after the input.

// File: rtl/servo_pkg.sv
`timescale 1ns/1ps
package servo_pkg;
    parameter int unsigned DW    = 16;
    parameter int unsigned CW    = 16;
    parameter int unsigned SHIFT = 14;
    parameter int unsigned NPROF = 4;
    parameter int unsigned LANES = 2;

    localparam int unsigned PW = $clog2(NPROF);
    localparam int unsigned AW = DW + CW + 4;

    typedef logic signed [DW-1:0] sample_t;
    typedef logic signed [CW-1:0] coef_t;
    typedef logic signed [AW-1:0] acc_t;

    localparam acc_t Y_MAX = acc_t'((64'd1 << (DW-1)) - 64'd1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FWD0,
        ST_FWD1,
        ST_FBK,
        ST_WRITE
    } seq_e;

    function automatic sample_t clip_unit(input acc_t a);
        acc_t s;
        s = a >>> SHIFT;
        if (s < 0)
            return '0;
        else if (s > Y_MAX)
            return sample_t'(Y_MAX);
        else
            return sample_t'(s);
    endfunction
endpackage

// File: rtl/servo_profile_bank.sv
`timescale 1ns/1ps
module servo_profile_bank
    import servo_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_prof,
    input  sample_t       wr_val,
    input  logic [PW-1:0] op_idx,
    output sample_t       op_y0,
    input  logic [PW-1:0] view_idx,
    output sample_t       view_y0,
    output sample_t       view_y1
);
    typedef struct packed {
        sample_t [NPROF-1:0] y0;
        sample_t [NPROF-1:0] y1;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            bank_d.y1[wr_prof] = bank_q.y0[wr_prof];
            bank_d.y0[wr_prof] = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign op_y0   = bank_q.y0[op_idx];
    assign view_y0 = bank_q.y0[view_idx];
    assign view_y1 = bank_q.y1[view_idx];

    for (genvar p = 0; p < NPROF; p++) begin : g_prof_chk
        assert_y_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !bank_q.y0[p][DW-1]);
        assert_hist_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_prof == PW'(p)) |=> (bank_q.y1[p] == $past(bank_q.y0[p])));
        assert_other_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_prof == PW'(p)) |=> $stable(bank_q.y0[p]));
    end
endmodule

// File: rtl/servo_mac_seq.sv
`timescale 1ns/1ps
module servo_mac_seq
    import servo_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adc_valid,
    input  sample_t             adc_sample,
    input  logic [PW-1:0]       profile_sel,
    input  logic                held,
    input  coef_t [NPROF-1:0]   b0_all,
    input  coef_t [NPROF-1:0]   b1_all,
    input  coef_t [NPROF-1:0]   a1_all,
    input  coef_t [NPROF-1:0]   off_all,
    input  sample_t             y0_act,
    output logic [PW-1:0]       act_prof,
    output logic                wr_en,
    output sample_t             wr_val,
    output logic                done
);
    typedef struct packed {
        seq_e          st;
        logic [PW-1:0] prof;
        sample_t       x0;
        sample_t       x1;
        acc_t          acc;
        logic          done;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (adc_valid) begin
                    seq_d.x1 = seq_q.x0;
                    seq_d.x0 = adc_sample;
                    if (!held) begin
                        seq_d.st   = ST_FWD0;
                        seq_d.prof = profile_sel;
                    end
                end
            end
            ST_FWD0: begin
                seq_d.acc = (acc_t'(off_all[seq_q.prof]) <<< SHIFT)
                          + acc_t'(b0_all[seq_q.prof]) * acc_t'(seq_q.x0);
                seq_d.st  = ST_FWD1;
            end
            ST_FWD1: begin
                seq_d.acc = seq_q.acc + acc_t'(b1_all[seq_q.prof]) * acc_t'(seq_q.x1);
                seq_d.st  = ST_FBK;
            end
            ST_FBK: begin
                seq_d.acc = seq_q.acc + acc_t'(a1_all[seq_q.prof]) * acc_t'(y0_act);
                seq_d.st  = ST_WRITE;
            end
            ST_WRITE: begin
                seq_d.st   = ST_IDLE;
                seq_d.done = 1'b1;
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign act_prof = seq_q.prof;
    assign wr_en    = (seq_q.st == ST_WRITE);
    assign wr_val   = clip_unit(seq_q.acc);
    assign done     = seq_q.done;

    assert_x_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE && adc_valid) |=>
            (seq_q.x0 == $past(adc_sample) && seq_q.x1 == $past(seq_q.x0)));
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st != ST_IDLE) |=> ($stable(seq_q.x0) && $stable(seq_q.x1)));
    assert_hold_no_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_IDLE && held) |=> (seq_q.st == ST_IDLE));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.done |=> !seq_q.done);
endmodule

// File: rtl/servo_iq_scaler.sv
`timescale 1ns/1ps
module servo_iq_scaler
    import servo_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  sample_t             gain,
    input  sample_t [LANES-1:0] lane_in,
    output sample_t [LANES-1:0] lane_out
);
    typedef logic signed [2*DW-1:0] wide_t;

    sample_t [LANES-1:0] out_d, out_q;

    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            if (enable)
                out_d[k] = sample_t'((wide_t'(lane_in[k]) * wide_t'(gain)) >>> (DW-1));
            else
                out_d[k] = lane_in[k];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign lane_out = out_q;

    for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
        assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !enable |=> (out_q[k] == $past(lane_in[k])));
        assert_zero_gain_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (enable && gain == '0) |=> (out_q[k] == '0));
    end
endmodule

// File: rtl/iir_servo_channel.sv
`timescale 1ns/1ps
module iir_servo_channel
    import servo_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         adc_valid,
    input  logic [DW-1:0]                adc_sample,
    input  logic [PW-1:0]                profile_sel,
    input  logic                         servo_en,
    input  logic                         servo_hold,
    input  logic [NPROF-1:0][CW-1:0]     coef_b0,
    input  logic [NPROF-1:0][CW-1:0]     coef_b1,
    input  logic [NPROF-1:0][CW-1:0]     coef_a1,
    input  logic [NPROF-1:0][CW-1:0]     coef_off,
    input  logic [DW-1:0]                i_in,
    input  logic [DW-1:0]                q_in,
    output logic [DW-1:0]                i_out,
    output logic [DW-1:0]                q_out,
    output logic [DW-1:0]                y_out,
    output logic [DW-1:0]                y_prev,
    output logic                         y_done
);
    logic                held;
    logic [PW-1:0]       act_prof;
    logic                wr_en;
    sample_t             wr_val;
    sample_t             op_y0;
    sample_t             view_y0;
    sample_t             view_y1;
    sample_t [LANES-1:0] lanes_in;
    sample_t [LANES-1:0] lanes_out;

    assign held = servo_hold | ~servo_en;

    servo_mac_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .adc_valid   (adc_valid),
        .adc_sample  (sample_t'(adc_sample)),
        .profile_sel (profile_sel),
        .held        (held),
        .b0_all      (coef_b0),
        .b1_all      (coef_b1),
        .a1_all      (coef_a1),
        .off_all     (coef_off),
        .y0_act      (op_y0),
        .act_prof    (act_prof),
        .wr_en       (wr_en),
        .wr_val      (wr_val),
        .done        (y_done)
    );

    servo_profile_bank u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_prof  (act_prof),
        .wr_val   (wr_val),
        .op_idx   (act_prof),
        .op_y0    (op_y0),
        .view_idx (profile_sel),
        .view_y0  (view_y0),
        .view_y1  (view_y1)
    );

    assign lanes_in = {q_in, i_in};

    servo_iq_scaler u_scale (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (servo_en),
        .gain     (view_y0),
        .lane_in  (lanes_in),
        .lane_out (lanes_out)
    );

    assign i_out  = lanes_out[0];
    assign q_out  = lanes_out[1];
    assign y_out  = view_y0;
    assign y_prev = view_y1;
endmodule

// File: tb/iir_servo_channel_test.sv
`timescale 1ns/1ps
module iir_servo_channel_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic adc_valid = 1'b0;
    logic [15:0] adc_sample = '0;
    logic [1:0] profile_sel = '0;
    logic servo_en = 1'b0;
    logic servo_hold = 1'b1;
    logic [3:0][15:0] coef_b0, coef_b1, coef_a1, coef_off;
    logic [15:0] i_in = '0, q_in = '0;
    logic [15:0] i_out, q_out, y_out, y_prev;
    logic y_done;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    iir_servo_channel uut (
        .clk(clk), .rst_n(rst_n), .adc_valid(adc_valid), .adc_sample(adc_sample),
        .profile_sel(profile_sel), .servo_en(servo_en), .servo_hold(servo_hold),
        .coef_b0(coef_b0), .coef_b1(coef_b1), .coef_a1(coef_a1), .coef_off(coef_off),
        .i_in(i_in), .q_in(q_in), .i_out(i_out), .q_out(q_out),
        .y_out(y_out), .y_prev(y_prev), .y_done(y_done)
    );

    typedef struct packed {
        logic [1:0]  prof;
        logic        en;
        logic        hold;
        logic [15:0] x;
        logic        upd;
        logic [15:0] y;
        logic [15:0] yp;
    } vec_t;

    // p0: y=x0 ; p1: y=y0+x0 ; p2: y=0x1000+x1/2 ; p3: y=0x7FFF-x0
    localparam vec_t VEC [13] = '{
        '{2'd0, 1'b1, 1'b0, 16'h1234, 1'b1, 16'h1234, 16'h0000}, // R2
        '{2'd0, 1'b1, 1'b0, 16'hF800, 1'b1, 16'h0000, 16'h1234}, // R3 negative clip
        '{2'd1, 1'b1, 1'b0, 16'h2000, 1'b1, 16'h2000, 16'h0000}, // R4 fresh profile
        '{2'd1, 1'b1, 1'b0, 16'h3000, 1'b1, 16'h5000, 16'h2000}, // R2 feedback
        '{2'd1, 1'b1, 1'b0, 16'h4000, 1'b1, 16'h7FFF, 16'h5000}, // R3 overflow clip
        '{2'd1, 1'b1, 1'b1, 16'h0100, 1'b0, 16'h7FFF, 16'h5000}, // R6 hold
        '{2'd2, 1'b1, 1'b0, 16'h0200, 1'b1, 16'h1080, 16'h0000}, // R5 x1 moved under hold
        '{2'd2, 1'b1, 1'b0, 16'hC000, 1'b1, 16'h1100, 16'h1080}, // R2 offset
        '{2'd2, 1'b1, 1'b0, 16'h0000, 1'b1, 16'h0000, 16'h1100}, // R3 negative clip
        '{2'd3, 1'b1, 1'b0, 16'hFF00, 1'b1, 16'h7FFF, 16'h0000}, // R3 overflow via offset
        '{2'd3, 1'b1, 1'b0, 16'h7000, 1'b1, 16'h0FFF, 16'h7FFF}, // R2 negative gain
        '{2'd0, 1'b0, 1'b0, 16'h0500, 1'b0, 16'h0000, 16'h1234}, // R7 disabled acts as hold
        '{2'd0, 1'b1, 1'b0, 16'h0600, 1'b1, 16'h0600, 16'h0000}  // R9 history shift
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drives one sample, returns first done position and done pulse count
    task automatic apply_sample(input logic [15:0] x, input logic [1:0] p, input logic en,
                                input logic hd, output int lat, output int cnt);
        @(negedge clk);
        adc_valid = 1'b1; adc_sample = x; profile_sel = p; servo_en = en; servo_hold = hd;
        @(negedge clk);
        adc_valid = 1'b0;
        lat = 0; cnt = 0;
        for (int k = 1; k <= 10; k++) begin
            if (y_done) begin
                cnt++;
                if (lat == 0) lat = k;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lat, cnt;
        coef_b0  = {16'hC000, 16'h0000, 16'h4000, 16'h4000};
        coef_b1  = {16'h0000, 16'h2000, 16'h0000, 16'h0000};
        coef_a1  = {16'h0000, 16'h0000, 16'h4000, 16'h0000};
        coef_off = {16'h7FFF, 16'h1000, 16'h0000, 16'h0000};
        repeat (3) @(negedge clk);
        chk("R1 y_out in reset", y_out, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 y_out", y_out, 16'h0000);
        chk("R1 y_prev", y_prev, 16'h0000);
        chk("R1 i_out", i_out, 16'h0000);
        chk("R1 q_out", q_out, 16'h0000);
        chk("R1 y_done", {15'd0, y_done}, 16'h0000);

        for (int v = 0; v < 13; v++) begin
            apply_sample(VEC[v].x, VEC[v].prof, VEC[v].en, VEC[v].hold, lat, cnt);
            if (VEC[v].upd) begin
                chk($sformatf("R9 done latency vec %0d", v), 16'(lat), 16'd5);
                chk($sformatf("R9 done width vec %0d", v), 16'(cnt), 16'd1);
            end else begin
                chk($sformatf("R6 R7 no done vec %0d", v), 16'(cnt), 16'd0);
            end
            chk($sformatf("R2 R3 R4 y_out vec %0d", v), y_out, VEC[v].y);
            chk($sformatf("R9 y_prev vec %0d", v), y_prev, VEC[v].yp);
        end

        // R4: select profile 1 without a sample
        profile_sel = 2'd1; servo_en = 1'b1; servo_hold = 1'b0;
        #1;
        chk("R4 view y0 of profile 1", y_out, 16'h7FFF);
        chk("R4 view y1 of profile 1", y_prev, 16'h5000);

        // R8: scaling with near full-scale gain
        @(negedge clk);
        i_in = 16'h4000; q_in = 16'h8000;
        @(negedge clk);
        chk("R8 i full gain", i_out, 16'h3FFF);
        chk("R8 q full gain", q_out, 16'h8001);

        // R8: scaling with profile 0 gain 0x0600
        profile_sel = 2'd0; i_in = 16'h1000; q_in = 16'hF000;
        @(negedge clk);
        chk("R8 i small gain", i_out, 16'h00C0);
        chk("R8 q small gain", q_out, 16'hFF40);

        // R7: bypass when disabled
        servo_en = 1'b0; i_in = 16'h1234; q_in = 16'hABCD;
        @(negedge clk);
        chk("R7 i bypass", i_out, 16'h1234);
        chk("R7 q bypass", q_out, 16'hABCD);
        servo_en = 1'b1; i_in = '0; q_in = '0;

        // R10: strobe during busy is dropped
        @(negedge clk);
        adc_valid = 1'b1; adc_sample = 16'h0300; profile_sel = 2'd0;
        @(negedge clk);
        adc_valid = 1'b0;
        @(negedge clk);
        adc_valid = 1'b1; adc_sample = 16'h7000;
        @(negedge clk);
        adc_valid = 1'b0;
        repeat (10) @(negedge clk);
        chk("R10 result from first sample", y_out, 16'h0300);
        apply_sample(16'h0000, 2'd2, 1'b1, 1'b0, lat, cnt);
        chk("R5 R10 x1 holds first sample", y_out, 16'h1180);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule